// File: doc/BRIEF.md
# External Memory Controller Command Sequencer

This block sits at the top of an external SDRAM controller and decides which operating state the controller is in. Software writes a 3-bit operation code into a write-only command word. The block checks the code against the current state and hands legal operations to a lower sequencer through a start/done handshake. It commits the new state only when the sequencer reports completion. The four visible states are configuration, ready (data traffic allowed), paused and low power. When reset is released the block is in the configuration state without being told to go there.

Only one operation runs at a time. A command that arrives while another is running waits in a single-entry slot, and a newer write replaces whatever is in that slot. The legality check is made when a command is issued to the sequencer, not when it is written. An illegal command is dropped and raises a sticky error flag. The block also gates writes to a configuration register and tracks whether the SDRAM banks were left open (ACTIVE) or closed (IDLE) by the last operation carried out in the ready state.

Top module: `memctl_cmd_ctl`

## Requirements
- R1: After reset the state output reads configuration (0), and `busy`, `cmd_err`, `bank_active`, `acc_ok` and `seq_start` are all low.
- R2: The operation is taken from `cmd_wdata[2:0]` and bits above 2 have no effect. The codes are 0 = go, 1 = sleep, 2 = wakeup, 3 = pause, 4 = configure. Codes 5, 6 and 7 are discarded: they do not raise `busy` and do not set the error flag.
- R3: The state output uses 0 = configuration, 1 = ready, 2 = pause, 3 = low power. Go is legal in configuration and in pause and leads to ready. `acc_ok` is high exactly while the state is ready.
- R4: Pause is legal only in ready and leads to pause. Configure is legal only in pause and leads to configuration.
- R5: Sleep is legal in ready and in pause and leads to low power. Wakeup is legal only in low power. It returns to the state held just before sleep, or to pause when `WAKE_RESUME` is 0.
- R6: A legal command produces a one-cycle `seq_start` pulse with its code on `seq_cmd`. The state output changes only in the cycle after `seq_done` is seen while that command is running.
- R7: A command written while another is running, or in the same cycle that another is issued, is held and issued after the running one completes.
- R8: The hold slot has one entry. A second write while it is occupied replaces the held command.
- R9: A command that is not legal in the state at issue time leaves the state unchanged and sets `cmd_err`, which stays high until reset.
- R10: `busy` is high while a command is running or held.
- R11: A configuration write is acknowledged on `cfg_ack` and stored into `cfg_q` only in the configuration state. In any other state it is ignored.
- R12: In ready, `acc_req` sets `bank_active` and `refr_done` clears it, with `acc_req` winning when both arrive in the same cycle. Outside ready both are ignored, so on entering pause `bank_active` still shows the last ready-state operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | REG_W | Command word, operation in bits 2:0 |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | CFG_W | Configuration write data |
| cfg_ack | output | 1 | Configuration write accepted this cycle |
| cfg_q | output | CFG_W | Stored configuration value |
| seq_start | output | 1 | One-cycle start pulse to the sequencer |
| seq_cmd | output | 3 | Operation code handed to the sequencer |
| seq_done | input | 1 | Sequencer reports the running operation finished |
| acc_req | input | 1 | A read or write was carried out on the SDRAM |
| acc_ok | output | 1 | Data accesses permitted |
| refr_done | input | 1 | An auto-refresh was carried out |
| bank_active | output | 1 | SDRAM left ACTIVE (1) or IDLE (0) |
| ctl_state | output | 2 | Current controller state |
| busy | output | 1 | Command running or held |
| cmd_err | output | 1 | Sticky flag for a dropped illegal command |

## Verification
Two functions can meet in one cycle: a new command write can land in the cycle where the held command is issued, and an SDRAM access can arrive in the cycle where a refresh completes. The bench writes two commands on back-to-back cycles, so the second write meets the issue of the first. It then checks that both run in order and that the final state is the one the second command leads to. It also pulses `acc_req` and `refr_done` together in ready and expects `bank_active` to read ACTIVE afterwards.

// File: rtl/memctl_cmd_pkg.sv
package memctl_cmd_pkg;

   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_GO     = 3'd0,
      OP_SLEEP  = 3'd1,
      OP_WAKE   = 3'd2,
      OP_PAUSE  = 3'd3,
      OP_CONFIG = 3'd4
   } op_e;

   typedef enum logic [1:0] {
      ST_CONFIG = 2'd0,
      ST_READY  = 2'd1,
      ST_PAUSE  = 2'd2,
      ST_LOWPWR = 2'd3
   } ctl_state_e;

   function automatic logic op_known(input logic [OP_W-1:0] code);
      return code <= 3'd4;
   endfunction

endpackage

// File: rtl/memctl_cmd_slot.sv
// Single-entry hold slot for decoded operation codes; newest write wins.
module memctl_cmd_slot
   import memctl_cmd_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [OP_W-1:0] wr_code,
   input  logic            take,
   output logic            pend_v,
   output op_e             pend_op
);

   logic wr_ok;
   assign wr_ok = wr_en && op_known(wr_code);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_v  <= 1'b0;
         pend_op <= OP_GO;
      end else if (wr_ok) begin
         pend_v  <= 1'b1;
         pend_op <= op_e'(wr_code);
      end else if (take) begin
         pend_v  <= 1'b0;
      end
   end

endmodule

// File: rtl/memctl_state_core.sv
// Legality check, issue to the sequencer, and state commit on completion.
module memctl_state_core
   import memctl_cmd_pkg::*;
#(
   parameter bit WAKE_RESUME = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pend_v,
   input  op_e             pend_op,
   input  logic            seq_done,
   output logic            take,
   output logic            seq_start,
   output logic [OP_W-1:0] seq_cmd,
   output ctl_state_e      st_q,
   output logic            exec_q,
   output logic            err_q
);

   ctl_state_e tgt_q, prev_q, tgt_n, wake_tgt;
   logic       legal;

   generate
      if (WAKE_RESUME) begin : g_wake_resume
         assign wake_tgt = prev_q;
      end else begin : g_wake_pause
         assign wake_tgt = ST_PAUSE;
      end
   endgenerate

   assign take = pend_v && !exec_q;

   always_comb begin
      legal = 1'b0;
      tgt_n = st_q;
      case (pend_op)
         OP_GO:
            if (st_q == ST_CONFIG || st_q == ST_PAUSE) begin
               legal = 1'b1;
               tgt_n = ST_READY;
            end
         OP_PAUSE:
            if (st_q == ST_READY) begin
               legal = 1'b1;
               tgt_n = ST_PAUSE;
            end
         OP_CONFIG:
            if (st_q == ST_PAUSE) begin
               legal = 1'b1;
               tgt_n = ST_CONFIG;
            end
         OP_SLEEP:
            if (st_q == ST_READY || st_q == ST_PAUSE) begin
               legal = 1'b1;
               tgt_n = ST_LOWPWR;
            end
         OP_WAKE:
            if (st_q == ST_LOWPWR) begin
               legal = 1'b1;
               tgt_n = wake_tgt;
            end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_CONFIG;
         tgt_q     <= ST_CONFIG;
         prev_q    <= ST_READY;
         exec_q    <= 1'b0;
         err_q     <= 1'b0;
         seq_start <= 1'b0;
         seq_cmd   <= '0;
      end else begin
         seq_start <= 1'b0;
         if (take) begin
            if (legal) begin
               exec_q    <= 1'b1;
               seq_start <= 1'b1;
               seq_cmd   <= pend_op;
               tgt_q     <= tgt_n;
               if (pend_op == OP_SLEEP) prev_q <= st_q;
            end else begin
               err_q <= 1'b1;
            end
         end else if (exec_q && seq_done) begin
            st_q   <= tgt_q;
            exec_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/memctl_bank_track.sv
// Remembers whether the last ready-state operation left the banks open.
module memctl_bank_track (
   input  logic clk,
   input  logic rst_n,
   input  logic in_ready,
   input  logic acc,
   input  logic refr,
   output logic active
);

   always_ff @(posedge clk) begin
      if (!rst_n)             active <= 1'b0;
      else if (in_ready) begin
         if (acc)             active <= 1'b1;
         else if (refr)       active <= 1'b0;
      end
   end

endmodule

// File: rtl/memctl_cmd_ctl.sv
module memctl_cmd_ctl
   import memctl_cmd_pkg::*;
#(
   parameter int REG_W       = 32,
   parameter int CFG_W       = 16,
   parameter bit WAKE_RESUME = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic [REG_W-1:0] cmd_wdata,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic             cfg_ack,
   output logic [CFG_W-1:0] cfg_q,
   output logic             seq_start,
   output logic [2:0]       seq_cmd,
   input  logic             seq_done,
   input  logic             acc_req,
   output logic             acc_ok,
   input  logic             refr_done,
   output logic             bank_active,
   output logic [1:0]       ctl_state,
   output logic             busy,
   output logic             cmd_err
);

   localparam int HI_W = REG_W - OP_W;

   generate
      if (REG_W <= OP_W) begin : g_bad_reg_w
         $error("REG_W must exceed the operation code width");
      end
      if (CFG_W < 1) begin : g_bad_cfg_w
         $error("CFG_W must be at least 1");
      end
   endgenerate

   logic             pend_v, take, exec_q;
   op_e              pend_op;
   ctl_state_e       st_q;
   logic [HI_W-1:0]  unused_hi;

   assign unused_hi = cmd_wdata[REG_W-1:OP_W];

   memctl_cmd_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cmd_we),
      .wr_code (cmd_wdata[OP_W-1:0]),
      .take    (take),
      .pend_v  (pend_v),
      .pend_op (pend_op)
   );

   memctl_state_core #(.WAKE_RESUME(WAKE_RESUME)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .pend_v    (pend_v),
      .pend_op   (pend_op),
      .seq_done  (seq_done),
      .take      (take),
      .seq_start (seq_start),
      .seq_cmd   (seq_cmd),
      .st_q      (st_q),
      .exec_q    (exec_q),
      .err_q     (cmd_err)
   );

   memctl_bank_track u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_ready (acc_ok),
      .acc      (acc_req),
      .refr     (refr_done),
      .active   (bank_active)
   );

   assign ctl_state = st_q;
   assign acc_ok    = (st_q == ST_READY);
   assign busy      = exec_q || pend_v;
   assign cfg_ack   = cfg_we && (st_q == ST_CONFIG);

   always_ff @(posedge clk) begin
      if (!rst_n)       cfg_q <= '0;
      else if (cfg_ack) cfg_q <= cfg_wdata;
   end

endmodule

// File: rtl/memctl_cmd_ctl_chk.sv
module memctl_cmd_ctl_chk #(
   parameter int CFG_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_we,
   input logic [2:0]       cmd_code,
   input logic             cfg_we,
   input logic [CFG_W-1:0] cfg_q,
   input logic             seq_start,
   input logic             seq_done,
   input logic             bank_active,
   input logic [1:0]       ctl_state,
   input logic             busy,
   input logic             cmd_err
);

   p_unknown_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && cmd_code > 3'd4 && !busy) |=> !busy);

   p_commit_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctl_state) |-> $past(seq_done));

   p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      seq_start |=> !seq_start);

   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |=> cmd_err);

   p_busy_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && cmd_code <= 3'd4) |=> busy);

   p_cfg_only_config_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_q) |-> ($past(ctl_state) == 2'd0 && $past(cfg_we)));

   p_bank_open_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bank_active) |-> $past(ctl_state) == 2'd1);

endmodule

bind memctl_cmd_ctl memctl_cmd_ctl_chk #(.CFG_W(CFG_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_we      (cmd_we),
   .cmd_code    (cmd_wdata[2:0]),
   .cfg_we      (cfg_we),
   .cfg_q       (cfg_q),
   .seq_start   (seq_start),
   .seq_done    (seq_done),
   .bank_active (bank_active),
   .ctl_state   (ctl_state),
   .busy        (busy),
   .cmd_err     (cmd_err)
);

// File: tb/memctl_cmd_ctl_test.sv
module memctl_cmd_ctl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_we = 1'b0;
   logic [31:0] cmd_wdata = '0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic        cfg_ack;
   logic [15:0] cfg_q;
   logic        seq_start;
   logic [2:0]  seq_cmd;
   logic        seq_done = 1'b0;
   logic        acc_req = 1'b0;
   logic        acc_ok;
   logic        refr_done = 1'b0;
   logic        bank_active;
   logic [1:0]  ctl_state;
   logic        busy;
   logic        cmd_err;

   int checks = 0;
   int errors = 0;
   int lat = 0;
   int cnt = -1;
   logic [2:0] last_cmd = 3'd7;

   always #10 clk = ~clk;

   memctl_cmd_ctl uut (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack), .cfg_q(cfg_q),
      .seq_start(seq_start), .seq_cmd(seq_cmd), .seq_done(seq_done),
      .acc_req(acc_req), .acc_ok(acc_ok), .refr_done(refr_done),
      .bank_active(bank_active), .ctl_state(ctl_state), .busy(busy),
      .cmd_err(cmd_err)
   );

   // sequencer model: answers each start after lat cycles
   always @(negedge clk) begin
      seq_done = 1'b0;
      if (seq_start) begin
         cnt = lat;
         last_cmd = seq_cmd;
      end
      if (cnt == 0) begin
         seq_done = 1'b1;
         cnt = -1;
      end else if (cnt > 0) begin
         cnt = cnt - 1;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic write_cmd(input logic [31:0] d);
      @(negedge clk);
      cmd_we = 1'b1;
      cmd_wdata = d;
      @(negedge clk);
      cmd_we = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 60 && busy; i++) @(negedge clk);
   endtask

   task automatic pulse(input bit a, input bit r);
      @(negedge clk);
      acc_req = a;
      refr_done = r;
      @(negedge clk);
      acc_req = 1'b0;
      refr_done = 1'b0;
   endtask

   task automatic cfg_write(input logic [15:0] d, input logic exp_ack, input string req);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = d;
      #1 check(req, cfg_ack, exp_ack);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 state", ctl_state, 0);
      check("R1 busy", busy, 0);
      check("R1 err", cmd_err, 0);
      check("R1 bank", bank_active, 0);
      check("R1 acc_ok", acc_ok, 0);
      check("R1 seq_start", seq_start, 0);
   endtask

   task automatic t_cfg_and_go();
      cfg_write(16'h1234, 1'b1, "R11 ack in config");
      check("R11 stored", cfg_q, 16'h1234);
      lat = 2;
      write_cmd(32'd0);
      check("R6 state held while running", ctl_state, 0);
      wait_idle();
      check("R3 go to ready", ctl_state, 1);
      check("R3 acc_ok", acc_ok, 1);
      check("R6 seq_cmd", last_cmd, 3'd0);
      cfg_write(16'hBEEF, 1'b0, "R11 no ack outside config");
      check("R11 value kept", cfg_q, 16'h1234);
   endtask

   task automatic t_bank();
      lat = 0;
      pulse(1'b1, 1'b0);
      check("R12 access opens", bank_active, 1);
      write_cmd(32'hFFFF_FFFB);       // pause with upper bits set
      wait_idle();
      check("R2 upper bits ignored", ctl_state, 2);
      check("R12 open in pause", bank_active, 1);
      check("R3 no access in pause", acc_ok, 0);
      pulse(1'b0, 1'b1);
      check("R12 refresh ignored outside ready", bank_active, 1);
      write_cmd(32'd0);
      wait_idle();
      pulse(1'b0, 1'b1);
      check("R12 refresh closes", bank_active, 0);
      pulse(1'b1, 1'b1);
      check("R12 access wins", bank_active, 1);
      pulse(1'b0, 1'b1);
      write_cmd(32'd3);
      wait_idle();
      check("R4 pause", ctl_state, 2);
      check("R12 idle in pause", bank_active, 0);
   endtask

   task automatic t_config_unknown();
      write_cmd(32'd4);
      wait_idle();
      check("R4 configure", ctl_state, 0);
      write_cmd(32'd6);
      check("R2 unknown no busy", busy, 0);
      @(negedge clk);
      check("R2 unknown state", ctl_state, 0);
      check("R2 unknown no err", cmd_err, 0);
   endtask

   task automatic t_queue();
      lat = 4;
      write_cmd(32'd0);
      write_cmd(32'd3);
      for (int i = 0; i < 40 && ctl_state != 2'd1; i++) @(negedge clk);
      check("R7 first done", ctl_state, 1);
      check("R10 busy while held", busy, 1);
      wait_idle();
      check("R7 queued ran", ctl_state, 2);
   endtask

   task automatic t_overwrite();
      lat = 6;
      write_cmd(32'd0);
      write_cmd(32'd3);
      write_cmd(32'd1);
      check("R10 busy", busy, 1);
      wait_idle();
      check("R8 overwrite sleep", ctl_state, 3);
      check("R9 no err", cmd_err, 0);
      lat = 0;
      write_cmd(32'd2);
      wait_idle();
      check("R5 wake resumes", ctl_state, 1);
   endtask

   task automatic t_back_to_back();
      @(negedge clk);
      cmd_we = 1'b1;
      cmd_wdata = 32'd3;
      @(negedge clk);
      cmd_wdata = 32'd4;
      @(negedge clk);
      cmd_we = 1'b0;
      wait_idle();
      check("R7 same cycle write", ctl_state, 0);
   endtask

   task automatic t_illegal();
      write_cmd(32'd3);
      wait_idle();
      check("R9 state kept", ctl_state, 0);
      check("R9 err set", cmd_err, 1);
      write_cmd(32'd0);
      wait_idle();
      check("R9 err sticky", cmd_err, 1);
      check("R3 go after err", ctl_state, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cfg_and_go();
      t_bank();
      t_config_unknown();
      t_queue();
      t_overwrite();
      t_back_to_back();
      t_illegal();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule